// File: doc/BRIEF.md
# Load Detect Status Controller

This block sits beside the power switch of a charging port. It watches qualified flags from external current comparators, and from them it decides whether a load is drawing current from the port. The decision comes out as an active-low load-present output. While a load is absent in the deep-sleep wake scheme, the block also holds a select that picks a small wake current limit. Current sensing and threshold generation stay outside the block. Here they are reduced to level flags that are already synchronous to the block clock, together with a slow timebase strobe of nominally 1 kHz.

The block decodes a four-bit charging-mode code into one of two detection schemes. In the wake scheme the low-current comparators are used: the 55 mA wake limit, and a falling reset threshold near 45 mA. When a load is found, the block moves the port to the high current limit. It drops back to the wake limit once the load has been gone for a long qualification time. The port-management scheme uses the load-detect comparator, whose threshold is about 700 mA. It has a short set time and a longer reset time. In one of its two codes, a battery-charging primary-detection event also marks the load as present. Every qualification time is counted in timebase ticks. Any break in a comparator flag sends its count back to zero.

Top module: `ldet_status_ctrl`

## Requirements
- R1: Detection runs only for mode codes 4'b0011 (wake scheme), 4'b0111 (port-management scheme) and 4'b1111 (port-management scheme with primary-detection event). For every other code, `load_n` stays 1 and `wake_lim_sel` stays 0.
- R2: In codes 0111 and 1111, `load_n` goes to 0 at the clock edge that samples the SET_TICKS-th tick of an unbroken run of `ld_above`.
- R3: In codes 0111 and 1111, a load that has been marked present is released (`load_n` goes to 1) at the edge that samples the NPW_RST_TICKS-th tick of an unbroken run of `ld_below`.
- R4: In code 1111, `prim_det` high at a clock edge marks the load present at that edge. In code 0111, `prim_det` has no effect.
- R5: In code 0011, `wake_lim_sel` is 1 while no load is present. When the edge samples the SET_TICKS-th tick of an unbroken run of `pw_above`, `load_n` goes to 0 and `wake_lim_sel` goes to 0 at that same edge.
- R6: In code 0011, at the edge that samples the PW_RST_TICKS-th tick of an unbroken run of `pw_below`, `load_n` returns to 1 and `wake_lim_sel` returns to 1.
- R7: If the active flag falls at any clock edge before its count is reached, the count restarts from zero and the output does not change.
- R8: A change of `mode` from one cycle to the next, or `en` low, forces `load_n` to 1 and `wake_lim_sel` to 0 in that same cycle. It also clears the stored load state and both counts at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Port enable; low clears detection |
| mode | input | 4 | Charging-mode code |
| tick | input | 1 | One-cycle timebase strobe (nominally 1 kHz) |
| ld_above | input | 1 | Current above the load-detect threshold |
| ld_below | input | 1 | Current below the load-detect threshold minus hysteresis |
| pw_above | input | 1 | Wake-limit comparator tripped |
| pw_below | input | 1 | Current below the wake reset threshold |
| prim_det | input | 1 | Primary-detection event seen on the data lines |
| load_n | output | 1 | Active-low load-present status |
| wake_lim_sel | output | 1 | 1 selects the small wake current limit; 0 selects the high limit |

## Verification
Each scheme receives comparator runs that stop one tick short of the qualification count, runs that reach it exactly, and runs broken by a single low cycle. These show whether the block counts ticks or cycles, and whether a broken run really restarts. The primary-detection event is applied in both port-management codes, which shows the code-specific path. Mode changes, `en` drops and inactive codes with every flag raised show whether clearing is immediate and whether any stale load state leaks out. A behavioural reference model is checked against both outputs on every cycle.

// File: rtl/ldet_pkg.sv
package ldet_pkg;

    typedef enum logic [1:0] {
        SCH_OFF    = 2'd0,
        SCH_WAKE   = 2'd1,
        SCH_PORT   = 2'd2,
        SCH_PORTBC = 2'd3
    } scheme_e;

    localparam logic [3:0] CODE_WAKE   = 4'b0011;
    localparam logic [3:0] CODE_PORT   = 4'b0111;
    localparam logic [3:0] CODE_PORTBC = 4'b1111;

    typedef struct packed {
        logic ld_above;
        logic ld_below;
        logic pw_above;
        logic pw_below;
        logic prim_det;
    } cmp_flags_t;

    function automatic scheme_e decode_mode(input logic [3:0] code);
        case (code)
            CODE_WAKE:   return SCH_WAKE;
            CODE_PORT:   return SCH_PORT;
            CODE_PORTBC: return SCH_PORTBC;
            default:     return SCH_OFF;
        endcase
    endfunction

    function automatic bit is_port_scheme(input scheme_e s);
        return (s == SCH_PORT) || (s == SCH_PORTBC);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ldet_mode_track.sv
module ldet_mode_track
    import ldet_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [3:0] mode,
    output scheme_e    scheme,
    output logic       restart
);
    logic [3:0] mode_prev;

    always_ff @(posedge clk) begin
        if (rst) mode_prev <= 4'b0000;
        else     mode_prev <= mode;
    end

    always_comb begin
        scheme  = decode_mode(mode);
        restart = (mode != mode_prev) || !en;
    end

endmodule

// File: rtl/ldet_qual_timer.sv
module ldet_qual_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic             cond,
    input  logic [CNT_W-1:0] target,
    output logic             done
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    always_comb begin
        last = target - CNT_W'(1);
        done = cond && tick && (cnt == last);
    end

    always_ff @(posedge clk) begin
        if (rst || clr || !cond) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == last) cnt <= '0;
            else             cnt <= cnt + CNT_W'(1);
        end
    end

    AST_CNT_BELOW_TARGET: assert property (@(posedge clk) disable iff (rst)
        !clr |-> (cnt < target)); // R7

    AST_BREAK_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (!cond || clr) |=> (cnt == '0)); // R7

endmodule

// File: rtl/ldet_status_core.sv
module ldet_status_core
    import ldet_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  scheme_e    scheme,
    input  cmp_flags_t flags,
    input  logic       set_done,
    input  logic       rel_done,
    output logic       set_cond,
    output logic       rel_cond,
    output logic       load_q,
    output logic       load_n,
    output logic       wake_lim_sel
);
    logic bc_event;
    logic active;

    always_comb begin
        active   = (scheme != SCH_OFF) && !restart;
        bc_event = (scheme == SCH_PORTBC) && flags.prim_det;
        set_cond = 1'b0;
        rel_cond = 1'b0;
        if (!load_q) begin
            if (scheme == SCH_WAKE)         set_cond = flags.pw_above;
            else if (is_port_scheme(scheme)) set_cond = flags.ld_above;
        end else begin
            if (scheme == SCH_WAKE)         rel_cond = flags.pw_below;
            else if (is_port_scheme(scheme)) rel_cond = flags.ld_below;
        end
        load_n       = !(load_q && active);
        wake_lim_sel = active && (scheme == SCH_WAKE) && !load_q;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            load_q <= 1'b0;
        end else if (!load_q) begin
            if (set_done || bc_event) load_q <= 1'b1;
        end else if (rel_done) begin
            load_q <= 1'b0;
        end
    end

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
        restart |=> !load_q); // R8

    AST_LIMIT_MATCHES_LOAD: assert property (@(posedge clk) disable iff (rst)
        (scheme == SCH_WAKE && !restart && !load_n) |-> !wake_lim_sel); // R5

endmodule

// File: rtl/ldet_status_ctrl.sv
module ldet_status_ctrl
    import ldet_pkg::*;
#(
    parameter int SET_TICKS     = 200,
    parameter int NPW_RST_TICKS = 3000,
    parameter int PW_RST_TICKS  = 15000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [3:0] mode,
    input  logic       tick,
    input  logic       ld_above,
    input  logic       ld_below,
    input  logic       pw_above,
    input  logic       pw_below,
    input  logic       prim_det,
    output logic       load_n,
    output logic       wake_lim_sel
);
    localparam int MAX_TICKS = max3(SET_TICKS, NPW_RST_TICKS, PW_RST_TICKS);
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    scheme_e          scheme;
    logic             restart;
    cmp_flags_t       flags;
    logic             set_cond, rel_cond, set_done, rel_done, load_q;
    logic [CNT_W-1:0] set_target, rel_target;

    always_comb begin
        flags      = '{ld_above: ld_above, ld_below: ld_below,
                       pw_above: pw_above, pw_below: pw_below,
                       prim_det: prim_det};
        set_target = CNT_W'(SET_TICKS);
        rel_target = (scheme == SCH_WAKE) ? CNT_W'(PW_RST_TICKS) : CNT_W'(NPW_RST_TICKS);
    end

    ldet_mode_track u_mode (
        .clk(clk), .rst(rst), .en(en), .mode(mode),
        .scheme(scheme), .restart(restart)
    );

    ldet_qual_timer #(.CNT_W(CNT_W)) u_set_tmr (
        .clk(clk), .rst(rst), .clr(restart), .tick(tick),
        .cond(set_cond), .target(set_target), .done(set_done)
    );

    ldet_qual_timer #(.CNT_W(CNT_W)) u_rel_tmr (
        .clk(clk), .rst(rst), .clr(restart), .tick(tick),
        .cond(rel_cond), .target(rel_target), .done(rel_done)
    );

    ldet_status_core u_core (
        .clk(clk), .rst(rst), .restart(restart), .scheme(scheme), .flags(flags),
        .set_done(set_done), .rel_done(rel_done), .set_cond(set_cond),
        .rel_cond(rel_cond), .load_q(load_q), .load_n(load_n),
        .wake_lim_sel(wake_lim_sel)
    );

    AST_OFF_CODE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (scheme == SCH_OFF) |-> (load_n && !wake_lim_sel)); // R1

    AST_SET_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (load_q && !$past(load_q)) |-> ($past(set_done) || $past(scheme == SCH_PORTBC && prim_det))); // R2

    AST_PRIM_ONLY_BC: assert property (@(posedge clk) disable iff (rst)
        (load_q && !$past(load_q) && !$past(set_done)) |-> $past(scheme == SCH_PORTBC)); // R4

    AST_RELEASE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (!load_q && $past(load_q)) |-> ($past(rel_done) || $past(restart))); // R3

endmodule

// File: tb/ldet_status_ctrl_tb.sv
module ldet_status_ctrl_tb;
    localparam int SET_T = 20;
    localparam int NRST_T = 50;
    localparam int PRST_T = 120;

    logic clk = 0, rst = 1, en = 0, tick = 0;
    logic [3:0] mode = 4'b0000;
    logic ld_above = 0, ld_below = 0, pw_above = 0, pw_below = 0, prim_det = 0;
    logic load_n, wake_lim_sel;

    int checks = 0, failures = 0, cycles = 0, tdiv = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ldet_status_ctrl #(.SET_TICKS(SET_T), .NPW_RST_TICKS(NRST_T), .PW_RST_TICKS(PRST_T)) u_dut (
        .clk(clk), .rst(rst), .en(en), .mode(mode), .tick(tick),
        .ld_above(ld_above), .ld_below(ld_below), .pw_above(pw_above),
        .pw_below(pw_below), .prim_det(prim_det),
        .load_n(load_n), .wake_lim_sel(wake_lim_sel)
    );

    // timebase: one strobe every third cycle, changed on falling edges
    always @(negedge clk) begin
        tdiv = (tdiv == 2) ? 0 : tdiv + 1;
        tick = (tdiv == 2);
    end

    // behavioural reference model
    int m_load = 0, m_sc = 0, m_rc = 0;
    logic [3:0] m_prev = 4'b0000;

    function automatic int kind(input logic [3:0] c);
        if (c == 4'b0011) return 1;
        if (c == 4'b0111) return 2;
        if (c == 4'b1111) return 3;
        return 0;
    endfunction

    always @(posedge clk) begin
        int k;
        if (rst) begin
            m_load = 0; m_sc = 0; m_rc = 0; m_prev = 4'b0000;
        end else begin
            k = kind(mode);
            if (mode != m_prev || !en) begin
                m_load = 0; m_sc = 0; m_rc = 0;
            end else if (m_load == 0) begin
                m_rc = 0;
                if ((k == 1 && pw_above) || (k >= 2 && ld_above)) begin
                    if (tick) m_sc++;
                    if (m_sc == SET_T) begin m_load = 1; m_sc = 0; end
                end else m_sc = 0;
                if (k == 3 && prim_det) begin m_load = 1; m_sc = 0; end
            end else begin
                m_sc = 0;
                if ((k == 1 && pw_below) || (k >= 2 && ld_below)) begin
                    if (tick) m_rc++;
                    if (m_rc == ((k == 1) ? PRST_T : NRST_T)) begin m_load = 0; m_rc = 0; end
                end else m_rc = 0;
            end
            m_prev = mode;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #2;
        if (!rst && !finished) begin
            int k;
            bit live;
            string tag;
            k = kind(mode);
            live = (mode == m_prev) && en && (k != 0);
            tag = (k == 0) ? "R1" : (k == 1) ? "R5" : (k == 2) ? "R2" : "R4";
            chk(tag, load_n, !(live && m_load == 1));
            chk(tag, wake_lim_sel, live && k == 1 && m_load == 0);
        end
    end

    task automatic settle();
        @(posedge clk); #2;
    endtask

    task automatic wait_ticks(input int n);
        int got = 0;
        while (got < n) begin
            @(posedge clk); #2;
            if (tick) got++;
        end
    endtask

    task automatic drive(input logic [3:0] m, input logic e, input logic la, input logic lb,
                         input logic pa, input logic pb, input logic pd);
        @(negedge clk);
        mode = m; en = e; ld_above = la; ld_below = lb;
        pw_above = pa; pw_below = pb; prim_det = pd;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        settle();
        chk("R1", load_n, 1'b1);
        chk("R1", wake_lim_sel, 1'b0);

        // R2: port scheme, short run then full run
        drive(4'b0111, 1, 0, 0, 0, 0, 0);
        settle();
        drive(4'b0111, 1, 1, 0, 0, 0, 0);
        wait_ticks(SET_T - 1);
        chk("R2", load_n, 1'b1);
        wait_ticks(1);
        chk("R2", load_n, 1'b0);

        // R3: release after reset count, with a break first (R7)
        drive(4'b0111, 1, 0, 1, 0, 0, 0);
        wait_ticks(NRST_T - 5);
        drive(4'b0111, 1, 0, 0, 0, 0, 0);
        drive(4'b0111, 1, 0, 1, 0, 0, 0);
        wait_ticks(NRST_T - 1);
        chk("R7", load_n, 1'b0);
        wait_ticks(1);
        chk("R3", load_n, 1'b1);

        // R7: broken set run does not assert
        drive(4'b0111, 1, 1, 0, 0, 0, 0);
        wait_ticks(SET_T - 2);
        drive(4'b0111, 1, 0, 0, 0, 0, 0);
        drive(4'b0111, 1, 1, 0, 0, 0, 0);
        wait_ticks(SET_T - 1);
        chk("R7", load_n, 1'b1);
        drive(4'b0111, 1, 0, 0, 0, 0, 0);

        // R4: primary detection ignored in 0111, honoured in 1111
        drive(4'b0111, 1, 0, 0, 0, 0, 1);
        drive(4'b0111, 1, 0, 0, 0, 0, 0);
        settle();
        chk("R4", load_n, 1'b1);
        drive(4'b1111, 1, 0, 0, 0, 0, 0);
        drive(4'b1111, 1, 0, 0, 0, 0, 1);
        settle();
        chk("R4", load_n, 1'b0);
        drive(4'b1111, 1, 0, 0, 0, 0, 0);

        // R8: enable low clears at once and stays cleared
        drive(4'b1111, 0, 0, 0, 0, 0, 0);
        #1 chk("R8", load_n, 1'b1);
        drive(4'b1111, 1, 0, 0, 0, 0, 0);
        settle();
        chk("R8", load_n, 1'b1);

        // R5: wake scheme
        drive(4'b0011, 1, 0, 0, 0, 0, 0);
        settle(); settle();
        chk("R5", wake_lim_sel, 1'b1);
        drive(4'b0011, 1, 1, 0, 1, 0, 0);
        wait_ticks(SET_T - 1);
        chk("R5", load_n, 1'b1);
        wait_ticks(1);
        chk("R5", load_n, 1'b0);
        chk("R5", wake_lim_sel, 1'b0);

        // R6: long release, port flags ignored here
        drive(4'b0011, 1, 0, 1, 0, 1, 1);
        wait_ticks(PRST_T - 1);
        chk("R6", load_n, 1'b0);
        wait_ticks(1);
        chk("R6", load_n, 1'b1);
        chk("R6", wake_lim_sel, 1'b1);

        // R8: mode change drops a present load
        drive(4'b0011, 1, 0, 0, 1, 0, 0);
        wait_ticks(SET_T);
        chk("R5", load_n, 1'b0);
        drive(4'b0111, 1, 0, 0, 1, 0, 0);
        #1 chk("R8", load_n, 1'b1);
        settle();
        chk("R8", load_n, 1'b1);

        // R1: inactive codes with every flag raised
        for (int c = 0; c < 16; c++) begin
            if (c == 3 || c == 7 || c == 15) continue;
            drive(c[3:0], 1, 1, 0, 1, 0, 1);
            wait_ticks(SET_T + 2);
            chk("R1", load_n, 1'b1);
            chk("R1", wake_lim_sel, 1'b0);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule